// File: doc/BRIEF.md
# Descriptor Ring Queue Engine

This engine serves one endpoint direction by walking a circular chain of 16-byte transfer descriptors held in system memory. After software supplies a start address and a go pulse, the engine reads a descriptor one word at a time through a read port. A descriptor that hardware owns starts one data transfer at the buffer it names, using a length-handshake port. The engine then writes the result back, gives ownership back to software, optionally pulses a completion interrupt, and continues at the next-descriptor pointer.

One parameter selects the direction. In the receive variant the permitted length comes from the upper half of the info word, and the received byte count is written into the length word. In the transmit variant the byte count and a trailing zero-length-packet flag both come from the length word, and only the info word is written back. A descriptor marked for bypass is stepped over without any transfer. A descriptor that software still owns parks the engine until software issues a resume.

Top module: `desc_ring_engine`

## Requirements
- R1: After reset `cur_ptr` is 0, and `rd_req`, `wr_req`, `xfer_req` and `irq` are low.
- R2: A fetch reads the four descriptor words in order (info, next pointer, buffer address, length) at byte offsets 0, 4, 8 and 12 from the descriptor address. `rd_addr` holds steady while `rd_req` waits for `rd_ack`.
- R3: A descriptor with info bit 0 (hardware-own) set and info bit 2 clear produces exactly one transfer at its buffer address. `xfer_req` and `xfer_len` hold steady until `xfer_done`.
- R4: A descriptor with both info bit 0 and info bit 2 (bypass) set produces no transfer and no memory write. The engine moves on to its next pointer.
- R5: A descriptor with info bit 0 clear produces no transfer and no write, and `cur_ptr` stays at its address. A `resume` pulse makes the engine read that descriptor again.
- R6: Receive variant: `xfer_len` is info bits 31:16. After the transfer, the engine writes the length word (offset 12) before the info word. The written length word has bits 15:0 set to `xfer_count` and bits 31:16 unchanged.
- R7: Transmit variant: `xfer_len` is length-word bits 15:0 and `xfer_zlp` is length-word bit 29. The engine writes nothing but the info word.
- R8: On completion the info word is written back with bit 0 cleared and every other bit unchanged.
- R9: `irq` pulses for exactly one cycle, in the cycle after the info write is acknowledged, and only when info bit 7 is set.
- R10: A `stop` finishes the descriptor already in progress and then halts, with `cur_ptr` holding the next pointer. While parked on a descriptor software owns, `stop` halts at once.
- R11: `go` from the halted state loads `start_addr`. Next pointers are followed around the ring, so a ring of two descriptors wraps back to the first. All descriptor addresses are 16-byte aligned.
- R12: At most one of `rd_req`, `wr_req` and `xfer_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_addr | input | 32 | Address of the first descriptor |
| go | input | 1 | Start pulse, accepted only while halted |
| stop | input | 1 | Stop pulse |
| resume | input | 1 | Re-poll pulse while parked |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read address |
| rd_ack | input | 1 | Read accepted, data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | 32 | Memory write address |
| wr_data | output | 32 | Memory write data |
| wr_ack | input | 1 | Write accepted |
| xfer_req | output | 1 | Transfer request |
| xfer_addr | output | 32 | Transfer buffer address |
| xfer_len | output | LEN_W | Requested byte count |
| xfer_zlp | output | 1 | Trailing zero-length packet wanted |
| xfer_done | input | 1 | Transfer finished |
| xfer_count | input | LEN_W | Bytes actually moved |
| irq | output | 1 | Completion interrupt pulse |
| cur_ptr | output | 32 | Address of the descriptor being fetched or processed |

## Verification
Two things can land in the same cycle: a stop request and the write-back of a descriptor in flight. The bench raises `stop` one cycle after `go`, while the first descriptor is still being fetched. It then checks that this descriptor is still transferred and released, that the second descriptor's info word is untouched, and that `cur_ptr` stops on the second descriptor. The other coincidence is the interrupt pulse and the fetch of the next descriptor. The bench judges it with a wrapping two-descriptor ring, where two interrupts must be counted while reads for the following descriptor are already under way.

// File: rtl/dre_pkg.sv
package dre_pkg;
   localparam int DESC_WORDS = 4;
   localparam int W_INFO     = 0;
   localparam int W_NEXT     = 1;
   localparam int W_BUF      = 2;
   localparam int W_LEN      = 3;
   localparam int BIT_OWN    = 0;
   localparam int BIT_BYP    = 2;
   localparam int BIT_IOC    = 7;
   localparam int BIT_ZLP    = 29;
   localparam int RX_ALW_LSB = 16;

   typedef struct packed {
      logic [31:0] lenw;
      logic [31:0] bufa;
      logic [31:0] next;
      logic [31:0] info;
   } desc_t;

   typedef enum logic [2:0] {
      ST_HALT, ST_FETCH, ST_DECIDE, ST_XFER, ST_WLEN, ST_WINFO, ST_PARK
   } eng_state_t;
endpackage

// File: rtl/dre_fetch.sv
module dre_fetch
   import dre_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        kick,
   input  logic [31:0] base,
   output logic        rd_req,
   output logic [31:0] rd_addr,
   input  logic        rd_ack,
   input  logic [31:0] rd_data,
   output logic        done,
   output desc_t       desc
);
   localparam int IDX_W = $clog2(DESC_WORDS);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DESC_WORDS - 1);

   logic                  active;
   logic [IDX_W-1:0]      idx;
   logic [DESC_WORDS-1:0][31:0] words;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         done   <= 1'b0;
         words  <= '0;
      end else begin
         done <= 1'b0;
         if (kick) begin
            active <= 1'b1;
            idx    <= '0;
         end else if (active && rd_ack) begin
            words[idx] <= rd_data;
            idx        <= idx + 1'b1;
            if (idx == LAST) begin
               active <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   assign rd_req    = active;
   assign rd_addr   = base + 32'({idx, 2'b00});
   assign desc.info = words[W_INFO];
   assign desc.next = words[W_NEXT];
   assign desc.bufa = words[W_BUF];
   assign desc.lenw = words[W_LEN];
endmodule

// File: rtl/dre_decode.sv
module dre_decode
   import dre_pkg::*;
#(
   parameter bit DIR_RX = 1'b0,
   parameter int LEN_W  = 16
) (
   input  logic [31:0]      info,
   input  logic [31:0]      lenw,
   output logic             own,
   output logic             byp,
   output logic             ioc,
   output logic             zlp,
   output logic [LEN_W-1:0] req_len
);
   logic unused_bits;
   assign unused_bits = ^{info, lenw};

   assign own = info[BIT_OWN];
   assign byp = info[BIT_BYP];
   assign ioc = info[BIT_IOC];

   generate
      if (DIR_RX) begin : g_rx
         assign req_len = info[RX_ALW_LSB +: LEN_W];
         assign zlp     = 1'b0;
      end else begin : g_tx
         assign req_len = lenw[LEN_W-1:0];
         assign zlp     = lenw[BIT_ZLP];
      end
   endgenerate
endmodule

// File: rtl/desc_ring_engine.sv
module desc_ring_engine
   import dre_pkg::*;
#(
   parameter bit DIR_RX = 1'b0,
   parameter int LEN_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      start_addr,
   input  logic             go,
   input  logic             stop,
   input  logic             resume,
   output logic             rd_req,
   output logic [31:0]      rd_addr,
   input  logic             rd_ack,
   input  logic [31:0]      rd_data,
   output logic             wr_req,
   output logic [31:0]      wr_addr,
   output logic [31:0]      wr_data,
   input  logic             wr_ack,
   output logic             xfer_req,
   output logic [31:0]      xfer_addr,
   output logic [LEN_W-1:0] xfer_len,
   output logic             xfer_zlp,
   input  logic             xfer_done,
   input  logic [LEN_W-1:0] xfer_count,
   output logic             irq,
   output logic [31:0]      cur_ptr
);
   localparam logic [31:0] OFF_LEN = 32'(W_LEN * 4);

   generate
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("LEN_W must lie in 1..16");
      end
   endgenerate

   eng_state_t       state;
   logic [31:0]      cur;
   logic             kick, stop_pend, fdone;
   logic [LEN_W-1:0] cnt_q;
   desc_t            d;
   logic             d_own, d_byp, d_ioc;

   dre_fetch u_fetch (
      .clk, .rst_n, .kick, .base(cur),
      .rd_req, .rd_addr, .rd_ack, .rd_data,
      .done(fdone), .desc(d)
   );

   dre_decode #(.DIR_RX(DIR_RX), .LEN_W(LEN_W)) u_dec (
      .info(d.info), .lenw(d.lenw),
      .own(d_own), .byp(d_byp), .ioc(d_ioc),
      .zlp(xfer_zlp), .req_len(xfer_len)
   );

   logic halt_now;
   assign halt_now = stop_pend || stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_HALT;
         cur       <= '0;
         kick      <= 1'b0;
         stop_pend <= 1'b0;
         cnt_q     <= '0;
         irq       <= 1'b0;
      end else begin
         kick <= 1'b0;
         irq  <= 1'b0;
         if (stop) stop_pend <= 1'b1;
         unique case (state)
            ST_HALT: begin
               stop_pend <= 1'b0;
               if (go) begin
                  cur   <= start_addr;
                  kick  <= 1'b1;
                  state <= ST_FETCH;
               end
            end
            ST_FETCH: if (fdone) state <= ST_DECIDE;
            ST_DECIDE: begin
               if (!d_own) begin
                  state <= ST_PARK;
               end else if (d_byp) begin
                  cur <= d.next;
                  if (halt_now) state <= ST_HALT;
                  else begin
                     kick  <= 1'b1;
                     state <= ST_FETCH;
                  end
               end else begin
                  state <= ST_XFER;
               end
            end
            ST_XFER: if (xfer_done) begin
               cnt_q <= xfer_count;
               state <= DIR_RX ? ST_WLEN : ST_WINFO;
            end
            ST_WLEN: if (wr_ack) state <= ST_WINFO;
            ST_WINFO: if (wr_ack) begin
               irq <= d_ioc;
               cur <= d.next;
               if (halt_now) state <= ST_HALT;
               else begin
                  kick  <= 1'b1;
                  state <= ST_FETCH;
               end
            end
            ST_PARK: begin
               if (halt_now) state <= ST_HALT;
               else if (resume) begin
                  kick  <= 1'b1;
                  state <= ST_FETCH;
               end
            end
            default: state <= ST_HALT;
         endcase
      end
   end

   logic [31:0] len_wb, info_wb;
   generate
      if (LEN_W < 32) begin : g_lenwb
         assign len_wb = {d.lenw[31:LEN_W], cnt_q};
      end else begin : g_lenwb_full
         assign len_wb = 32'(cnt_q);
      end
   endgenerate
   assign info_wb = d.info & ~(32'd1 << BIT_OWN);

   assign wr_req    = (state == ST_WLEN) || (state == ST_WINFO);
   assign wr_addr   = (state == ST_WLEN) ? cur + OFF_LEN : cur;
   assign wr_data   = (state == ST_WLEN) ? len_wb : info_wb;
   assign xfer_req  = (state == ST_XFER);
   assign xfer_addr = d.bufa;
   assign cur_ptr   = cur;
endmodule

// File: rtl/dre_chk.sv
module dre_chk #(
   parameter bit DIR_RX = 1'b0,
   parameter int LEN_W  = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_req,
   input logic             rd_ack,
   input logic [31:0]      rd_addr,
   input logic             wr_req,
   input logic             wr_ack,
   input logic [31:0]      wr_addr,
   input logic [31:0]      wr_data,
   input logic             xfer_req,
   input logic             xfer_done,
   input logic [LEN_W-1:0] xfer_len,
   input logic             irq
);
   assert_one_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_req, wr_req, xfer_req}));

   assert_read_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

   assert_xfer_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && !xfer_done |=> xfer_req && $stable(xfer_len));

   assert_own_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && (wr_addr[3:0] == 4'h0) |-> !wr_data[0]);

   assert_irq_after_info_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(wr_req && wr_ack && (wr_addr[3:0] == 4'h0)));

   assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   generate
      if (!DIR_RX) begin : g_tx_chk
         assert_tx_info_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wr_req |-> (wr_addr[3:0] == 4'h0));
      end
   endgenerate
endmodule

bind desc_ring_engine dre_chk #(.DIR_RX(DIR_RX), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/desc_ring_engine_tb.sv
module desc_ring_engine_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [31:0] start_addr = '0;
   logic go_r = 0, go_t = 0, stop = 0, resume = 0;
   logic [15:0] rx_cnt = '0;

   logic        rd_req_r, wr_req_r, xfer_req_r, xfer_zlp_r, irq_r;
   logic [31:0] rd_addr_r, wr_addr_r, wr_data_r, xfer_addr_r, cur_ptr_r;
   logic [15:0] xfer_len_r;
   logic        rd_req_t, wr_req_t, xfer_req_t, xfer_zlp_t, irq_t;
   logic [31:0] rd_addr_t, wr_addr_t, wr_data_t, xfer_addr_t, cur_ptr_t;
   logic [15:0] xfer_len_t;
   logic        xd_r = 0, xd_t = 0;

   logic [31:0] mem [16];
   logic        hw_en = 0;
   logic [3:0]  hw_idx = '0;
   logic [31:0] hw_data = '0;

   int nrd = 0, nx_r = 0, nx_t = 0, nirq_r = 0, nirq_t = 0, nmulti = 0;
   logic [3:0]  wl0 = '0, wl1 = '0;
   logic [31:0] lx_addr = '0, lx_addr_prev = '0;
   logic [15:0] lx_len = '0;
   logic        lx_zlp = 0;
   int xc_r = 0, xc_t = 0;

   desc_ring_engine #(.DIR_RX(1'b1), .LEN_W(16)) u_dut (
      .clk, .rst_n, .start_addr, .go(go_r), .stop, .resume,
      .rd_req(rd_req_r), .rd_addr(rd_addr_r), .rd_ack(rd_req_r), .rd_data(mem[rd_addr_r[5:2]]),
      .wr_req(wr_req_r), .wr_addr(wr_addr_r), .wr_data(wr_data_r), .wr_ack(wr_req_r),
      .xfer_req(xfer_req_r), .xfer_addr(xfer_addr_r), .xfer_len(xfer_len_r), .xfer_zlp(xfer_zlp_r),
      .xfer_done(xd_r), .xfer_count(rx_cnt), .irq(irq_r), .cur_ptr(cur_ptr_r));

   desc_ring_engine #(.DIR_RX(1'b0), .LEN_W(16)) u_dut_tx (
      .clk, .rst_n, .start_addr, .go(go_t), .stop, .resume,
      .rd_req(rd_req_t), .rd_addr(rd_addr_t), .rd_ack(rd_req_t), .rd_data(mem[rd_addr_t[5:2]]),
      .wr_req(wr_req_t), .wr_addr(wr_addr_t), .wr_data(wr_data_t), .wr_ack(wr_req_t),
      .xfer_req(xfer_req_t), .xfer_addr(xfer_addr_t), .xfer_len(xfer_len_t), .xfer_zlp(xfer_zlp_t),
      .xfer_done(xd_t), .xfer_count(16'd0), .irq(irq_t), .cur_ptr(cur_ptr_t));

   // memory, transfer responders and monitors
   always @(posedge clk) begin
      if (hw_en) mem[hw_idx] <= hw_data;
      if (wr_req_r) mem[wr_addr_r[5:2]] <= wr_data_r;
      if (wr_req_t) mem[wr_addr_t[5:2]] <= wr_data_t;
      if (wr_req_r || wr_req_t) begin
         wl1 <= wl0;
         wl0 <= wr_req_r ? wr_addr_r[3:0] : wr_addr_t[3:0];
      end
      if (rd_req_r || rd_req_t) nrd <= nrd + 1;
      if ((32'(rd_req_r) + 32'(wr_req_r) + 32'(xfer_req_r)) > 1) nmulti <= nmulti + 1;
      if ((32'(rd_req_t) + 32'(wr_req_t) + 32'(xfer_req_t)) > 1) nmulti <= nmulti + 1;
      if (irq_r) nirq_r <= nirq_r + 1;
      if (irq_t) nirq_t <= nirq_t + 1;
      if (xd_r) xd_r <= 1'b0;
      else if (xfer_req_r) begin
         xc_r <= xc_r + 1;
         if (xc_r == 1) begin
            xd_r <= 1'b1; xc_r <= 0; nx_r <= nx_r + 1;
            lx_addr_prev <= lx_addr; lx_addr <= xfer_addr_r; lx_len <= xfer_len_r; lx_zlp <= xfer_zlp_r;
         end
      end
      if (xd_t) xd_t <= 1'b0;
      else if (xfer_req_t) begin
         xc_t <= xc_t + 1;
         if (xc_t == 1) begin
            xd_t <= 1'b1; xc_t <= 0; nx_t <= nx_t + 1;
            lx_addr_prev <= lx_addr; lx_addr <= xfer_addr_t; lx_len <= xfer_len_t; lx_zlp <= xfer_zlp_t;
         end
      end
   end

   int nchk = 0, nfail = 0;
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic poke(input logic [3:0] idx, input logic [31:0] data);
      hw_en = 1'b1; hw_idx = idx; hw_data = data;
      @(negedge clk);
      hw_en = 1'b0;
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1;
      @(negedge clk);
      sig = 1'b0;
   endtask

   task automatic put_desc(input logic [3:0] slot, input logic [31:0] info, nxt, bufa, lenw);
      poke(slot * 4 + 0, info);
      poke(slot * 4 + 1, nxt);
      poke(slot * 4 + 2, bufa);
      poke(slot * 4 + 3, lenw);
   endtask

   // columns: info, length word, rx count, exp transfers, exp info, exp length word, exp irqs, exp cur_ptr
   localparam logic [31:0] VEC [0:3][0:7] = '{
      '{32'h0064_0081, 32'hABCD_0000, 32'd50,  32'd1, 32'h0064_0080, 32'hABCD_0032, 32'd1, 32'h10},
      '{32'h0200_0001, 32'h0000_FFFF, 32'd512, 32'd1, 32'h0200_0000, 32'h0000_0200, 32'd0, 32'h10},
      '{32'h0010_0085, 32'h1234_5678, 32'd7,   32'd0, 32'h0010_0085, 32'h1234_5678, 32'd0, 32'h10},
      '{32'h0008_0080, 32'h0000_0011, 32'd9,   32'd0, 32'h0008_0080, 32'h0000_0011, 32'd0, 32'h00}
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin : main
      int bx, bi, br;
      for (int i = 0; i < 16; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cur_ptr", cur_ptr_r, 32'h0);
      chk("R1 requests", {29'd0, rd_req_r, wr_req_r, xfer_req_r}, 32'h0);
      chk("R1 irq", {31'd0, irq_r | irq_t}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < 4; v++) begin
         put_desc(0, VEC[v][0], 32'h10, 32'h1000 + 32'(v) * 32'h100, VEC[v][1]);
         put_desc(1, 32'h0, 32'h0, 32'h0, 32'h0);
         rx_cnt = VEC[v][2][15:0];
         start_addr = 32'h0;
         bx = nx_r; bi = nirq_r; br = nrd;
         pulse(go_r);
         repeat (60) @(negedge clk);
         chk("R3/R4/R5 transfer count", 32'(nx_r - bx), VEC[v][3]);
         if (VEC[v][3] != 0) begin
            chk("R6 rx length", {16'd0, lx_len}, {16'd0, VEC[v][0][31:16]});
            chk("R3 buffer address", lx_addr, 32'h1000 + 32'(v) * 32'h100);
         end
         chk("R8 info word", mem[0], VEC[v][4]);
         chk("R6 length word", mem[3], VEC[v][5]);
         chk("R9 irq count", 32'(nirq_r - bi), VEC[v][6]);
         chk("R4/R5/R11 cur_ptr", cur_ptr_r, VEC[v][7]);
         if (v == 0) begin
            chk("R2 read count", 32'(nrd - br), 32'd8);
            chk("R6 write order", {24'd0, wl1, wl0}, 32'h0000_00C0);
         end
         if (v != 3) begin
            pulse(stop);
            repeat (3) @(negedge clk);
         end
      end

      // R5 resume: engine parked at 0x00 from the last vector
      poke(0, 32'h0004_0001);
      rx_cnt = 16'd3;
      bx = nx_r;
      pulse(resume);
      repeat (60) @(negedge clk);
      chk("R5 resume transfer", 32'(nx_r - bx), 32'd1);
      chk("R5 resume info", mem[0], 32'h0004_0000);
      chk("R5 resume length", mem[3], 32'h0000_0003);
      chk("R5 resume cur_ptr", cur_ptr_r, 32'h10);
      pulse(stop);
      repeat (3) @(negedge clk);

      // R10 stop during the first descriptor
      put_desc(0, 32'h0004_0001, 32'h10, 32'h1000, 32'h0);
      put_desc(1, 32'h0004_0001, 32'h20, 32'h1100, 32'h0);
      put_desc(2, 32'h0, 32'h0, 32'h0, 32'h0);
      bx = nx_r;
      go_r = 1'b1;
      @(negedge clk);
      go_r = 1'b0;
      pulse(stop);
      repeat (60) @(negedge clk);
      chk("R10 in-flight finished", 32'(nx_r - bx), 32'd1);
      chk("R10 first released", mem[0], 32'h0004_0000);
      chk("R10 second untouched", mem[4], 32'h0004_0001);
      chk("R10 halt pointer", cur_ptr_r, 32'h10);

      // R11 two-entry ring wraps
      put_desc(0, 32'h0002_0081, 32'h10, 32'h2000, 32'h0);
      put_desc(1, 32'h0002_0081, 32'h00, 32'h3000, 32'h0);
      bx = nx_r; bi = nirq_r;
      pulse(go_r);
      repeat (80) @(negedge clk);
      chk("R11 ring transfers", 32'(nx_r - bx), 32'd2);
      chk("R11 ring order", lx_addr_prev, 32'h2000);
      chk("R11 ring order last", lx_addr, 32'h3000);
      chk("R9 ring irqs", 32'(nirq_r - bi), 32'd2);
      chk("R11 wrapped pointer", cur_ptr_r, 32'h0);
      pulse(stop);
      repeat (3) @(negedge clk);

      // R7 transmit variant
      put_desc(0, 32'h0000_0081, 32'h10, 32'h4000, 32'h2000_0040);
      put_desc(1, 32'h0, 32'h0, 32'h0, 32'h0);
      bx = nx_t; bi = nirq_t;
      pulse(go_t);
      repeat (60) @(negedge clk);
      chk("R7 tx transfers", 32'(nx_t - bx), 32'd1);
      chk("R7 tx length", {16'd0, lx_len}, 32'd64);
      chk("R7 tx zlp", {31'd0, lx_zlp}, 32'd1);
      chk("R7 tx length word kept", mem[3], 32'h2000_0040);
      chk("R8 tx info", mem[0], 32'h0000_0080);
      chk("R9 tx irq", 32'(nirq_t - bi), 32'd1);
      chk("R11 tx cur_ptr", cur_ptr_t, 32'h10);
      pulse(stop);
      repeat (3) @(negedge clk);

      chk("R12 request overlap", 32'(nmulti), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule